// File: doc/BRIEF.md
# Reset and Power Mode Sequencer

This block decides which operating mode a small 8-bit controller core is in, and it turns that mode into the enables and pin overrides the rest of the chip needs. It filters the raw reset pin, so that a short high pulse does not reset the core. It tracks four modes: run, idle, power down and emulation. Idle stops only the CPU clock. Power down also stops the oscillator. Emulation hands the board pins over to an external tester.

The core raises one-cycle requests to enter idle or power down. The interrupt controller supplies an "any enabled interrupt pending" flag, together with the enable and level-mode settings for the two external interrupt pins. The block drives the CPU clock enable, the oscillator enable and the reset to the core. It also drives a RAM write inhibit and a registered drive code for ALE, for PSEN and for each of the four 8-bit ports. The pad logic applies those codes.

Emulation is selected by pin straps that are read at the moment a qualified reset ends. There are two ways out of power down. A qualified reset is one. The other is an enabled, level-sensitive external interrupt: the oscillator is restarted, the block waits a programmable settle time, and it then waits for the pin to go high again.

Top module: `pmode_ctrl`

## Requirements
- R1: `core_rst_o` goes high on the 24th consecutive rising edge at which `rst_pin_i` is sampled high while `osc_en_o` is high. Any low sample clears the count.
- R2: `core_rst_o` goes low at the first edge where `rst_pin_i` is sampled low. At that same edge the mode becomes emulation (`mode_o`=3) if `ale_pin_i`=0 and `psen_pin_i`=1, and run (`mode_o`=0) otherwise. The mode stays run while `core_rst_o` is held.
- R3: In run, a pulse on `idle_req_i` moves the block to idle (`mode_o`=1) with `cpu_clk_en_o`=0 and `osc_en_o`=1. In idle, `irq_any_i` returns the block to run with the CPU clock enabled at the next edge.
- R4: In run, a pulse on `pdn_req_i` moves the block to power down (`mode_o`=2) with both enables low. If `pdn_req_i` and `idle_req_i` arrive in the same cycle, power down wins.
- R5: In power down, INTk wakes the block only when `int_en_i[k]`=1, `int_lvl_i[k]`=1 and `int_pin_i[k]`=0. The oscillator enable rises at that edge. The CPU clock returns at the first edge where at least `settle_len_i` edges have passed since the oscillator restarted and every waking pin is sampled high. If the pin is already high, that is `settle_len_i`+1 edges after `osc_en_o` rises. An interrupt that is edge-mode or disabled leaves the oscillator off.
- R6: In power down, a high `rst_pin_i` restarts the oscillator at the next edge. Reset qualification then runs as in R1, and the block ends in run.
- R7: ALE and PSEN drive codes (0 normal, 1 drive high, 2 drive low, 3 weak pull-up) are 0 in run, 1 in idle and 2 in power down.
- R8: `port_drv_o[2k+1:2k]` is the code for port k (0 data, 1 float, 2 address, 3 weak pull-up). All ports are 0 in run and whenever `ext_exec_i`=0. When `ext_exec_i`=1, port 0 is 1 in both idle and power down, and port 2 is 2 in idle and 0 in power down.
- R9: A high `rst_pin_i` sampled in idle returns the block to run with `cpu_clk_en_o`=1 and sets `ram_wr_inhibit_o`. This takes priority over `irq_any_i` in the same cycle. The inhibit clears one edge after `core_rst_o` is seen high, or at the first edge where `rst_pin_i` is sampled low.
- R10: In emulation, port 0 is 1 (float), ports 1 to 3 and ALE/PSEN are 3 (weak pull-up), and both enables stay high. Idle and power-down requests are ignored; only a qualified reset leaves the mode.
- R11: After the block's own `rst`, the outputs are: mode run, both enables 1, `core_rst_o`=0, no inhibit, all drive codes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_pin_i | input | 1 | Raw reset pin level |
| ale_pin_i | input | 1 | Sampled ALE pin (emulation strap) |
| psen_pin_i | input | 1 | Sampled PSEN pin (emulation strap) |
| idle_req_i | input | 1 | Software idle request pulse |
| pdn_req_i | input | 1 | Software power-down request pulse |
| irq_any_i | input | 1 | Any enabled interrupt pending |
| int_en_i | input | N_INT | External interrupt enables |
| int_lvl_i | input | N_INT | 1 = level-sensitive external interrupt |
| int_pin_i | input | N_INT | External interrupt pins, active low |
| ext_exec_i | input | 1 | Core executes from external memory |
| settle_len_i | input | SETTLE_W | Oscillator settle clocks after wake |
| mode_o | output | 2 | Mode: 0 run, 1 idle, 2 power down, 3 emulation |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| core_rst_o | output | 1 | Qualified reset to the core |
| ram_wr_inhibit_o | output | 1 | Blocks internal RAM writes |
| ale_drv_o | output | 2 | ALE drive code |
| psen_drv_o | output | 2 | PSEN drive code |
| port_drv_o | output | 2*N_PORTS | Per-port drive codes, port k at bits 2k+1:2k |

## Verification
Two functions can compete in the same cycle in idle: the reset pin rising and an enabled interrupt arriving. The bench raises both `rst_pin_i` and `irq_any_i` in one cycle. It then checks that the block is in run with the RAM inhibit set, which shows the reset path took priority over the plain interrupt wake. Idle and power-down requests are also pulsed together, and the bench checks that the block lands in power down. In a third case the reset release and the strap sampling fall on the same edge, and the bench checks both the emulation outcome and the run outcome at that edge.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
  typedef enum logic [1:0] {
    MD_RUN  = 2'd0,
    MD_IDLE = 2'd1,
    MD_PDN  = 2'd2,
    MD_EMU  = 2'd3
  } mode_t;

  typedef enum logic [1:0] {
    PIN_NORM = 2'd0,
    PIN_HIGH = 2'd1,
    PIN_LOW  = 2'd2,
    PIN_WEAK = 2'd3
  } pin_drv_t;

  typedef enum logic [1:0] {
    PRT_DATA  = 2'd0,
    PRT_FLOAT = 2'd1,
    PRT_ADDR  = 2'd2,
    PRT_WEAK  = 2'd3
  } prt_drv_t;

  typedef enum logic [1:0] {
    PD_SLEEP = 2'd0,
    PD_WAKE  = 2'd1,
    PD_RSTW  = 2'd2
  } pd_sub_t;
endpackage

// File: rtl/pmode_rst_qual.sv
module pmode_rst_qual #(
  parameter int QUAL_LEN = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic osc_run,
  output logic qual
);
  localparam int CW = $clog2(QUAL_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_LEN - 1);

  logic [CW-1:0] cnt;

  // consecutive high samples while the oscillator runs; any break restarts
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      qual <= 1'b0;
    end else if (!osc_run || !pin) begin
      cnt  <= '0;
      qual <= 1'b0;
    end else begin
      if (cnt != LAST) cnt <= cnt + 1'b1;
      qual <= (cnt == LAST);
    end
  end
endmodule

// File: rtl/pmode_fsm.sv
module pmode_fsm
  import pmode_pkg::*;
#(
  parameter int SETTLE_W = 8,
  parameter int N_INT    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                core_rst,
  input  logic                rst_pin,
  input  logic                ale_pin,
  input  logic                psen_pin,
  input  logic                idle_req,
  input  logic                pdn_req,
  input  logic                irq_any,
  input  logic [N_INT-1:0]    int_en,
  input  logic [N_INT-1:0]    int_lvl,
  input  logic [N_INT-1:0]    int_pin,
  input  logic [SETTLE_W-1:0] settle_len,
  output mode_t               mode_q,
  output mode_t               mode_d,
  output logic                cpu_q,
  output logic                osc_q,
  output logic                inh_q
);
  localparam logic [SETTLE_W-1:0] CNT_MAX = {SETTLE_W{1'b1}};

  pd_sub_t             sub_q, sub_d;
  logic                cpu_d, osc_d, inh_d;
  logic [SETTLE_W-1:0] cnt_q, cnt_d;
  logic [N_INT-1:0]    wm_q, wm_d, wake;

  assign wake = int_en & int_lvl & ~int_pin;

  always_comb begin
    mode_d = mode_q;
    sub_d  = sub_q;
    cpu_d  = cpu_q;
    osc_d  = osc_q;
    inh_d  = inh_q;
    cnt_d  = cnt_q;
    wm_d   = wm_q;
    if (core_rst) begin
      mode_d = MD_RUN;
      sub_d  = PD_SLEEP;
      cpu_d  = 1'b1;
      osc_d  = 1'b1;
      inh_d  = 1'b0;
      cnt_d  = '0;
      wm_d   = '0;
      if (!rst_pin && !ale_pin && psen_pin) mode_d = MD_EMU;
    end else begin
      unique case (mode_q)
        MD_RUN: begin
          if (inh_q) begin
            if (!rst_pin) inh_d = 1'b0;
          end else if (pdn_req) begin
            mode_d = MD_PDN;
            sub_d  = PD_SLEEP;
            cpu_d  = 1'b0;
            osc_d  = 1'b0;
          end else if (idle_req) begin
            mode_d = MD_IDLE;
            cpu_d  = 1'b0;
          end
        end
        MD_IDLE: begin
          if (rst_pin) begin
            mode_d = MD_RUN;
            cpu_d  = 1'b1;
            inh_d  = 1'b1;
          end else if (irq_any) begin
            mode_d = MD_RUN;
            cpu_d  = 1'b1;
          end
        end
        MD_PDN: begin
          case (sub_q)
            PD_SLEEP: begin
              if (rst_pin) begin
                osc_d = 1'b1;
                sub_d = PD_RSTW;
              end else if (|wake) begin
                osc_d = 1'b1;
                sub_d = PD_WAKE;
                cnt_d = '0;
                wm_d  = wake;
              end
            end
            PD_WAKE: begin
              if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
              if ((cnt_q >= settle_len) && ((wm_q & ~int_pin) == '0)) begin
                mode_d = MD_RUN;
                sub_d  = PD_SLEEP;
                cpu_d  = 1'b1;
              end
            end
            PD_RSTW: begin
              if (!rst_pin) begin
                osc_d = 1'b0;
                sub_d = PD_SLEEP;
              end
            end
            default: sub_d = PD_SLEEP;
          endcase
        end
        MD_EMU: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_RUN;
      sub_q  <= PD_SLEEP;
      cpu_q  <= 1'b1;
      osc_q  <= 1'b1;
      inh_q  <= 1'b0;
      cnt_q  <= '0;
      wm_q   <= '0;
    end else begin
      mode_q <= mode_d;
      sub_q  <= sub_d;
      cpu_q  <= cpu_d;
      osc_q  <= osc_d;
      inh_q  <= inh_d;
      cnt_q  <= cnt_d;
      wm_q   <= wm_d;
    end
  end
endmodule

// File: rtl/pmode_pin_ovr.sv
module pmode_pin_ovr
  import pmode_pkg::*;
#(
  parameter int N_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  mode_t                mode_d,
  input  logic                 ext_exec,
  output logic [1:0]           ale_drv,
  output logic [1:0]           psen_drv,
  output logic [2*N_PORTS-1:0] port_drv
);
  logic [1:0] strobe_code;

  always_comb begin
    unique case (mode_d)
      MD_RUN:  strobe_code = PIN_NORM;
      MD_IDLE: strobe_code = PIN_HIGH;
      MD_PDN:  strobe_code = PIN_LOW;
      MD_EMU:  strobe_code = PIN_WEAK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_drv  <= PIN_NORM;
      psen_drv <= PIN_NORM;
    end else begin
      ale_drv  <= strobe_code;
      psen_drv <= strobe_code;
    end
  end

  for (genvar k = 0; k < N_PORTS; k++) begin : g_port
    logic [1:0] code, code_q;
    always_comb begin
      code = PRT_DATA;
      unique case (mode_d)
        MD_IDLE: begin
          if (ext_exec && k == 0) code = PRT_FLOAT;
          else if (ext_exec && k == 2) code = PRT_ADDR;
        end
        MD_PDN: begin
          if (ext_exec && k == 0) code = PRT_FLOAT;
        end
        MD_EMU: code = (k == 0) ? PRT_FLOAT : PRT_WEAK;
        MD_RUN: ;
      endcase
    end
    always_ff @(posedge clk) begin
      if (rst) code_q <= PRT_DATA;
      else     code_q <= code;
    end
    assign port_drv[2*k +: 2] = code_q;
  end
endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
  import pmode_pkg::*;
#(
  parameter int QUAL_LEN = 24,
  parameter int SETTLE_W = 8,
  parameter int N_INT    = 2,
  parameter int N_PORTS  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rst_pin_i,
  input  logic                  ale_pin_i,
  input  logic                  psen_pin_i,
  input  logic                  idle_req_i,
  input  logic                  pdn_req_i,
  input  logic                  irq_any_i,
  input  logic [N_INT-1:0]      int_en_i,
  input  logic [N_INT-1:0]      int_lvl_i,
  input  logic [N_INT-1:0]      int_pin_i,
  input  logic                  ext_exec_i,
  input  logic [SETTLE_W-1:0]   settle_len_i,
  output logic [1:0]            mode_o,
  output logic                  cpu_clk_en_o,
  output logic                  osc_en_o,
  output logic                  core_rst_o,
  output logic                  ram_wr_inhibit_o,
  output logic [1:0]            ale_drv_o,
  output logic [1:0]            psen_drv_o,
  output logic [2*N_PORTS-1:0]  port_drv_o
);
  mode_t mode_q, mode_d;
  logic  qual;

  pmode_rst_qual #(.QUAL_LEN(QUAL_LEN)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .pin     (rst_pin_i),
    .osc_run (osc_en_o),
    .qual    (qual)
  );

  pmode_fsm #(.SETTLE_W(SETTLE_W), .N_INT(N_INT)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .core_rst   (qual),
    .rst_pin    (rst_pin_i),
    .ale_pin    (ale_pin_i),
    .psen_pin   (psen_pin_i),
    .idle_req   (idle_req_i),
    .pdn_req    (pdn_req_i),
    .irq_any    (irq_any_i),
    .int_en     (int_en_i),
    .int_lvl    (int_lvl_i),
    .int_pin    (int_pin_i),
    .settle_len (settle_len_i),
    .mode_q     (mode_q),
    .mode_d     (mode_d),
    .cpu_q      (cpu_clk_en_o),
    .osc_q      (osc_en_o),
    .inh_q      (ram_wr_inhibit_o)
  );

  pmode_pin_ovr #(.N_PORTS(N_PORTS)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .mode_d   (mode_d),
    .ext_exec (ext_exec_i),
    .ale_drv  (ale_drv_o),
    .psen_drv (psen_drv_o),
    .port_drv (port_drv_o)
  );

  assign core_rst_o = qual;
  assign mode_o     = mode_q;
endmodule

// File: rtl/pmode_ctrl_chk.sv
module pmode_ctrl_chk #(
  parameter int QUAL_LEN = 24
) (
  input logic       clk,
  input logic       rst,
  input logic       rst_pin_i,
  input logic       osc_en_o,
  input logic       cpu_clk_en_o,
  input logic       core_rst_o,
  input logic       ram_wr_inhibit_o,
  input logic [1:0] mode_o,
  input logic [1:0] ale_drv_o,
  input logic [1:0] psen_drv_o,
  input logic [1:0] p0_drv
);
  localparam int HW = $clog2(QUAL_LEN + 1) + 1;
  localparam logic [HW-1:0] HSAT = HW'(QUAL_LEN);

  logic [HW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) hi_run <= '0;
    else if (rst_pin_i && osc_en_o) begin
      if (hi_run != HSAT) hi_run <= hi_run + 1'b1;
    end else hi_run <= '0;
  end

  p_qual_len_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst_o) |-> (hi_run >= HSAT));

  p_release_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst_o) |-> !$past(rst_pin_i));

  p_hold_run_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(core_rst_o) && core_rst_o) |-> (mode_o == 2'd0));

  p_idle_clk_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd1) |-> (!cpu_clk_en_o && osc_en_o));

  p_pdn_clk_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2) |-> !cpu_clk_en_o);

  p_osc_off_r4: assert property (@(posedge clk) disable iff (rst)
    !osc_en_o |-> (mode_o == 2'd2));

  p_wake_osc_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd0 && $past(mode_o) == 2'd2 && !$past(core_rst_o)) |-> $past(osc_en_o));

  p_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == 2'd1) |-> (ale_drv_o == 2'd1 && psen_drv_o == 2'd1)) and
    ((mode_o == 2'd2) |-> (ale_drv_o == 2'd2 && psen_drv_o == 2'd2)));

  p_inhibit_r9: assert property (@(posedge clk) disable iff (rst)
    ram_wr_inhibit_o |-> (cpu_clk_en_o && mode_o == 2'd0));

  p_emu_pins_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd3) |-> (p0_drv == 2'd1 && ale_drv_o == 2'd3 && psen_drv_o == 2'd3
                          && osc_en_o && cpu_clk_en_o));
endmodule

bind pmode_ctrl pmode_ctrl_chk #(.QUAL_LEN(QUAL_LEN)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .rst_pin_i        (rst_pin_i),
  .osc_en_o         (osc_en_o),
  .cpu_clk_en_o     (cpu_clk_en_o),
  .core_rst_o       (core_rst_o),
  .ram_wr_inhibit_o (ram_wr_inhibit_o),
  .mode_o           (mode_o),
  .ale_drv_o        (ale_drv_o),
  .psen_drv_o       (psen_drv_o),
  .p0_drv           (port_drv_o[1:0])
);

// File: tb/tb_pmode_ctrl.sv
module tb_pmode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [17:0] M_ALL  = 18'h3FFFF;
  localparam logic [17:0] M_MODE = 18'h30000;
  localparam logic [17:0] M_CPU  = 18'h08000;
  localparam logic [17:0] M_OSC  = 18'h04000;
  localparam logic [17:0] M_RST  = 18'h02000;
  localparam logic [17:0] M_INH  = 18'h01000;

  logic       clk = 1'b0;
  logic       rst;
  logic       rst_pin, ale_pin, psen_pin, idle_req, pdn_req, irq_any, ext_exec;
  logic [1:0] int_en, int_lvl, int_pin;
  logic [7:0] settle_len;
  logic [1:0] mode_o, ale_drv, psen_drv;
  logic       cpu_en, osc_en, core_rst, inh;
  logic [7:0] port_drv;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  string       q_rq[$];
  logic [17:0] q_mask[$];
  logic [17:0] q_exp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pmode_ctrl dut (
    .clk(clk), .rst(rst), .rst_pin_i(rst_pin), .ale_pin_i(ale_pin), .psen_pin_i(psen_pin),
    .idle_req_i(idle_req), .pdn_req_i(pdn_req), .irq_any_i(irq_any),
    .int_en_i(int_en), .int_lvl_i(int_lvl), .int_pin_i(int_pin), .ext_exec_i(ext_exec),
    .settle_len_i(settle_len), .mode_o(mode_o), .cpu_clk_en_o(cpu_en), .osc_en_o(osc_en),
    .core_rst_o(core_rst), .ram_wr_inhibit_o(inh), .ale_drv_o(ale_drv), .psen_drv_o(psen_drv),
    .port_drv_o(port_drv)
  );

  wire [17:0] obs = {mode_o, cpu_en, osc_en, core_rst, inh, ale_drv, psen_drv, port_drv};

  function automatic logic [17:0] mk(input logic [1:0] md, input logic c, input logic o,
                                     input logic r, input logic i, input logic [1:0] a,
                                     input logic [1:0] p, input logic [7:0] pt);
    return {md, c, o, r, i, a, p, pt};
  endfunction

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic expect_bits(input string rq, input logic [17:0] mask, input logic [17:0] exp);
    q_rq.push_back(rq); q_mask.push_back(mask); q_exp.push_back(exp);
  endtask

  task automatic chk_num(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    while (q_rq.size() > 0) begin
      string       rq;
      logic [17:0] m, e;
      rq = q_rq.pop_front(); m = q_mask.pop_front(); e = q_exp.pop_front();
      n_chk++;
      if ((obs & m) !== (e & m)) begin
        n_bad++;
        $display("FAIL %s actual=%05h expected=%05h mask=%05h", rq, obs & m, e & m, m);
      end
    end
  end

  task automatic pulse_idle(); idle_req = 1'b1; tick(1); idle_req = 1'b0; endtask
  task automatic pulse_pdn();  pdn_req  = 1'b1; tick(1); pdn_req  = 1'b0; endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    rst = 1'b1; rst_pin = 1'b0; ale_pin = 1'b1; psen_pin = 1'b1; idle_req = 1'b0;
    pdn_req = 1'b0; irq_any = 1'b0; ext_exec = 1'b0; int_en = 2'b00; int_lvl = 2'b00;
    int_pin = 2'b11; settle_len = 8'd4;
    tick(2); rst = 1'b0; tick(1);
    expect_bits("R11 reset state", M_ALL, mk(2'd0, 1, 1, 0, 0, 2'd0, 2'd0, 8'h00));

    // R1 exact qualification length
    rst_pin = 1'b1; tick(23);
    expect_bits("R1 23 samples no reset", M_RST, 18'h0);
    tick(1);
    expect_bits("R1 24th sample resets", M_RST | M_MODE, mk(2'd0, 0, 0, 1, 0, 0, 0, 0));
    rst_pin = 1'b0; tick(1);
    expect_bits("R2 release to run", M_ALL, mk(2'd0, 1, 1, 0, 0, 2'd0, 2'd0, 8'h00));

    // R1 low sample restarts count
    rst_pin = 1'b1; tick(20); rst_pin = 1'b0; tick(1); rst_pin = 1'b1; tick(23);
    expect_bits("R1 glitch restarts count", M_RST, 18'h0);
    tick(1);
    expect_bits("R1 full run after glitch", M_RST, M_RST);
    rst_pin = 1'b0; tick(1);

    // R3 idle and interrupt wake, R7 strobes high
    pulse_idle();
    expect_bits("R3 R7 idle entry", M_ALL, mk(2'd1, 0, 1, 0, 0, 2'd1, 2'd1, 8'h00));
    tick(3);
    irq_any = 1'b1; tick(1); irq_any = 1'b0;
    expect_bits("R3 interrupt wakes idle", M_ALL, mk(2'd0, 1, 1, 0, 0, 2'd0, 2'd0, 8'h00));

    // R8 idle under external execution
    ext_exec = 1'b1; pulse_idle();
    expect_bits("R8 idle ports external", M_ALL, mk(2'd1, 0, 1, 0, 0, 2'd1, 2'd1, 8'h21));
    irq_any = 1'b1; tick(1); irq_any = 1'b0;

    // R4 simultaneous requests, power down wins; R7 R8 pins
    idle_req = 1'b1; pdn_req = 1'b1; tick(1); idle_req = 1'b0; pdn_req = 1'b0;
    expect_bits("R4 R7 R8 power down", M_ALL, mk(2'd2, 0, 0, 0, 0, 2'd2, 2'd2, 8'h01));

    // R5 edge-mode and disabled pins ignored
    int_en = 2'b11; int_lvl = 2'b01; int_pin = 2'b01; tick(5);
    expect_bits("R5 edge-mode pin ignored", M_MODE | M_OSC | M_CPU, mk(2'd2, 0, 0, 0, 0, 0, 0, 0));
    int_en = 2'b10; int_lvl = 2'b11; int_pin = 2'b10; tick(5);
    expect_bits("R5 disabled pin ignored", M_MODE | M_OSC | M_CPU, mk(2'd2, 0, 0, 0, 0, 0, 0, 0));
    int_pin = 2'b11; tick(1);

    // R5 wake with short low pulse: settle_len+1 edges
    int_en = 2'b01; int_lvl = 2'b01; int_pin = 2'b10; tick(1); int_pin = 2'b11;
    expect_bits("R5 oscillator restarts", M_MODE | M_OSC | M_CPU, mk(2'd2, 0, 1, 0, 0, 0, 0, 0));
    n = 0;
    while (!cpu_en && n < 100) begin tick(1); n++; end
    chk_num("R5 settle edges", n, 5);
    expect_bits("R5 back in run", M_ALL, mk(2'd0, 1, 1, 0, 0, 2'd0, 2'd0, 8'h00));

    // R5 pin held low beyond settle: exit on edge after pin high
    pulse_pdn();
    int_pin = 2'b10; tick(11);
    expect_bits("R5 held low stays down", M_MODE | M_OSC | M_CPU, mk(2'd2, 0, 1, 0, 0, 0, 0, 0));
    int_pin = 2'b11; tick(1);
    expect_bits("R5 exit when pin high", M_MODE | M_CPU, mk(2'd0, 1, 0, 0, 0, 0, 0, 0));

    // R6 reset during power down
    pulse_pdn();
    rst_pin = 1'b1; tick(1);
    expect_bits("R6 oscillator restarts on reset", M_MODE | M_OSC | M_RST, mk(2'd2, 0, 1, 0, 0, 0, 0, 0));
    tick(23);
    expect_bits("R6 not yet qualified", M_RST, 18'h0);
    tick(1);
    expect_bits("R6 qualified", M_RST, M_RST);
    tick(1);
    expect_bits("R6 run under reset", M_MODE | M_CPU | M_OSC | M_RST, mk(2'd0, 1, 1, 1, 0, 0, 0, 0));

    // R2 R10 strap into emulation at release
    ale_pin = 1'b0; rst_pin = 1'b0; tick(1);
    expect_bits("R2 R10 emulation entry", M_ALL, mk(2'd3, 1, 1, 0, 0, 2'd3, 2'd3, 8'hFD));
    ale_pin = 1'b1;
    idle_req = 1'b1; pdn_req = 1'b1; tick(1); idle_req = 1'b0; pdn_req = 1'b0; tick(1);
    expect_bits("R10 requests ignored", M_MODE | M_CPU | M_OSC, mk(2'd3, 1, 1, 0, 0, 0, 0, 0));
    rst_pin = 1'b1; tick(25);
    expect_bits("R10 reset leaves emulation", M_MODE | M_RST, mk(2'd0, 0, 0, 1, 0, 0, 0, 0));
    rst_pin = 1'b0; tick(1);
    expect_bits("R2 ALE high strap gives run", M_MODE | M_RST, mk(2'd0, 0, 0, 0, 0, 0, 0, 0));

    // R2 PSEN low strap gives run
    rst_pin = 1'b1; tick(25); ale_pin = 1'b0; psen_pin = 1'b0; rst_pin = 1'b0; tick(1);
    expect_bits("R2 PSEN low strap gives run", M_MODE | M_RST, mk(2'd0, 0, 0, 0, 0, 0, 0, 0));
    ale_pin = 1'b1; psen_pin = 1'b1; ext_exec = 1'b0;

    // R9 reset and interrupt in idle in the same cycle
    pulse_idle();
    rst_pin = 1'b1; irq_any = 1'b1; tick(1); irq_any = 1'b0;
    expect_bits("R9 reset wins with inhibit", M_MODE | M_CPU | M_RST | M_INH, mk(2'd0, 1, 0, 0, 1, 0, 0, 0));
    tick(23);
    expect_bits("R9 inhibit as reset qualifies", M_RST | M_INH, M_RST | M_INH);
    tick(1);
    expect_bits("R9 inhibit clears under reset", M_RST | M_INH, M_RST);
    rst_pin = 1'b0; tick(1);

    // R9 short reset pulse from idle
    pulse_idle();
    rst_pin = 1'b1; tick(3);
    expect_bits("R9 inhibit during short pulse", M_INH | M_RST, M_INH);
    rst_pin = 1'b0; tick(1);
    expect_bits("R9 inhibit drops with pin", M_ALL, mk(2'd0, 1, 1, 0, 0, 2'd0, 2'd0, 8'h00));

    tick(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule